// File: doc/BRIEF.md
# Blit Scaling Factor Calculator

This block prepares the per-axis resampling setup for one rectangular copy job. Given the source crop extents, the destination crop extents, a quarter-turn rotation code and a flag that selects the trimming needed by legacy silicon revisions, it decides for each axis whether the picture is kept, shrunk or enlarged. It then produces a 16-bit fixed-point step factor for that axis. Each factor is an inverse ratio normalised to 2^16: the smaller extent, shifted left by sixteen, divided by the larger one.

Resampling happens ahead of rotation. A quarter or three-quarter turn therefore exchanges the destination width and height before they are compared with the source. One restoring divider, producing one quotient bit per clock, is shared by the two axes: the horizontal axis is computed first and the vertical axis second. A job is launched with a one-cycle `start`, and all results are published together with a one-cycle `done`. The results then stay unchanged until the next `done`.

Top module: `blit_scale_calc`

## Requirements
- R1: After a synchronous active-low reset, `done`, `div_err`, both mode outputs and both factor outputs are zero.
- R2: A `start` sampled high while idle is accepted, and `done` is high for exactly one cycle, 68 rising edges after the accepting edge, with all results updated on that same edge.
- R3: A `start` seen between the accepting edge and the edge that raises `done` is ignored, and input changes in that window do not alter the job's results; the block can accept a new job on the edge right after `done` rises.
- R4: Mode encoding per axis: 0 when the source extent equals the target extent, 1 (shrink) when the source is larger, 2 (enlarge) when the source is smaller; value 3 never appears.
- R5: An axis in mode 0 reports a factor of zero.
- R6: In shrink mode the factor is floor((target << 16) / source) + 1, saturated to 65535.
- R7: In enlarge mode the factor is floor(((source − 1) mod 2^16 << 16) / (target − 1)), saturated to 65535.
- R8: Rotation code bit 0 selects a quarter or three-quarter turn (codes 1 and 3): the horizontal target is then the destination height and the vertical target the destination width; codes 0 and 2 leave the destination axes unchanged.
- R9: With the legacy flag set and rotation code 1 or 3, the source height is reduced by 8 (mod 2^16) when the destination width equals the source height, and the source width is reduced by 16 (mod 2^16) when |source width − destination height| < 16; both tests use the original values.
- R10: With rotation code 0 or 2 the legacy flag has no effect on any result.
- R11: An enlarge axis whose divisor (target − 1) is zero reports factor 0, and `div_err` is 1 with that `done`; `div_err` is 0 for every job that has no such axis.
- R12: Between `done` pulses, the mode, factor and error outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Launch a job (accepted only when idle) |
| src_w | input | 16 | Source crop width |
| src_h | input | 16 | Source crop height |
| dst_w | input | 16 | Destination crop width |
| dst_h | input | 16 | Destination crop height |
| rot | input | 2 | Rotation code: 0, 1, 2, 3 for 0, 90, 180, 270 degrees |
| legacy | input | 1 | Apply the legacy-revision source trim |
| done | output | 1 | One-cycle completion pulse |
| mode_x | output | 2 | Horizontal mode (0 keep, 1 shrink, 2 enlarge) |
| mode_y | output | 2 | Vertical mode (0 keep, 1 shrink, 2 enlarge) |
| factor_x | output | 16 | Horizontal step factor |
| factor_y | output | 16 | Vertical step factor |
| div_err | output | 1 | A zero divisor was met in this job |

## Verification
Every result of a job appears on the 68th rising edge after the edge that accepted `start`. That edge count is the same for every operand pattern, because each axis always spends one setup cycle, 32 divider steps and one capture cycle. The reference model counts edges from acceptance in the same way, so it predicts `done` and the new output values for exactly that edge. The outputs are compared against the model on every falling edge: a late, early or doubled `done`, or a value that moves between pulses, is caught in the cycle where it occurs.

// File: rtl/scl_pkg.sv
// Shared types for the scaling factor calculator.
// Assumes: mode encoding is consumed downstream as a 2-bit field.
package scl_pkg;
    typedef enum logic [1:0] {
        SCL_NONE = 2'd0,
        SCL_DOWN = 2'd1,
        SCL_UP   = 2'd2
    } scl_mode_e;
endpackage

// File: rtl/scl_axis_prep.sv
// Maps the destination axes onto the scaling axes for the chosen rotation
// and applies the legacy-revision source trim.
// Assumes: rotation bit 0 marks a quarter or three-quarter turn; all
// subtractions wrap modulo 2^EXT_W.
module scl_axis_prep #(
    parameter int EXT_W    = 16,
    parameter int TRIM_H   = 8,
    parameter int TRIM_W   = 16,
    parameter int TRIM_WIN = 16
) (
    input  logic [EXT_W-1:0] src_w,
    input  logic [EXT_W-1:0] src_h,
    input  logic [EXT_W-1:0] dst_w,
    input  logic [EXT_W-1:0] dst_h,
    input  logic [1:0]       rot,
    input  logic             legacy,
    output logic [EXT_W-1:0] eff_src_w,
    output logic [EXT_W-1:0] eff_src_h,
    output logic [EXT_W-1:0] tgt_w,
    output logic [EXT_W-1:0] tgt_h
);
    localparam logic [EXT_W-1:0] H_CUT = EXT_W'(TRIM_H);
    localparam logic [EXT_W-1:0] W_CUT = EXT_W'(TRIM_W);
    localparam logic [EXT_W:0]   WIN   = (EXT_W+1)'(TRIM_WIN);

    logic           swap;
    logic [EXT_W:0] diff;
    logic [EXT_W:0] mag;
    logic           cut_h;
    logic           cut_w;

    // Purpose: choose target axes and decide the two trims.
    always_comb begin
        swap  = rot[0];
        tgt_w = swap ? dst_h : dst_w;
        tgt_h = swap ? dst_w : dst_h;
        diff  = {1'b0, src_w} - {1'b0, dst_h};
        mag   = diff[EXT_W] ? (~diff + 1'b1) : diff;
        cut_h = legacy && swap && (dst_w == src_h);
        cut_w = legacy && swap && (mag < WIN);
        eff_src_h = cut_h ? (src_h - H_CUT) : src_h;
        eff_src_w = cut_w ? (src_w - W_CUT) : src_w;
    end
endmodule

// File: rtl/scl_axis_plan.sv
// Per-axis planner: picks the scaling mode and the divider operands.
// Assumes: a bypassed axis (equal extents or zero divisor) still gets a
// harmless dummy division (0 / 1) so the schedule stays fixed.
module scl_axis_plan
    import scl_pkg::*;
#(
    parameter int EXT_W  = 16,
    parameter int FRAC_W = 16,
    localparam int NUM_W = EXT_W + FRAC_W
) (
    input  logic [EXT_W-1:0] src,
    input  logic [EXT_W-1:0] tgt,
    output logic [1:0]       mode,
    output logic [NUM_W-1:0] dividend,
    output logic [EXT_W-1:0] divisor,
    output logic             zero_div
);
    localparam logic [EXT_W-1:0] ONE = EXT_W'(1);

    logic [EXT_W-1:0] src_m1;
    logic [EXT_W-1:0] tgt_m1;

    // Purpose: classify the axis and form the normalised division.
    always_comb begin
        src_m1   = src - ONE;
        tgt_m1   = tgt - ONE;
        mode     = SCL_NONE;
        dividend = '0;
        divisor  = ONE;
        zero_div = 1'b0;
        if (src > tgt) begin
            mode     = SCL_DOWN;
            dividend = {tgt, {FRAC_W{1'b0}}};
            divisor  = src;
        end else if (src < tgt) begin
            mode = SCL_UP;
            if (tgt_m1 == '0) begin
                zero_div = 1'b1;
            end else begin
                dividend = {src_m1, {FRAC_W{1'b0}}};
                divisor  = tgt_m1;
            end
        end
    end
endmodule

// File: rtl/scl_restoring_div.sv
// Restoring unsigned divider, one quotient bit per clock.
// Assumes: den is never zero when load is raised; valid pulses once,
// NUM_W clocks after the load edge.
module scl_restoring_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 16,
    localparam int CNT_W = $clog2(NUM_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic [NUM_W-1:0] quo,
    output logic             valid
);
    logic [DEN_W:0]   rem;
    logic [DEN_W-1:0] dvs;
    logic [CNT_W-1:0] cnt;
    logic [DEN_W:0]   shifted;
    logic             fits;
    logic [DEN_W:0]   rem_nxt;

    // Purpose: one trial subtraction of the restoring algorithm.
    always_comb begin
        shifted = {rem[DEN_W-1:0], quo[NUM_W-1]};
        fits    = shifted >= {1'b0, dvs};
        rem_nxt = fits ? (shifted - {1'b0, dvs}) : shifted;
    end

    // Purpose: load operands, then shift one quotient bit per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem   <= '0;
            dvs   <= '0;
            quo   <= '0;
            cnt   <= '0;
            valid <= 1'b0;
        end else if (load) begin
            rem   <= '0;
            dvs   <= den;
            quo   <= num;
            cnt   <= CNT_W'(NUM_W);
            valid <= 1'b0;
        end else if (cnt != '0) begin
            rem   <= rem_nxt;
            quo   <= {quo[NUM_W-2:0], fits};
            cnt   <= cnt - CNT_W'(1);
            valid <= (cnt == CNT_W'(1));
        end else begin
            valid <= 1'b0;
        end
    end

    // The partial remainder stays below the divisor while running.
    p_rem_below_div_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> (rem < {1'b0, dvs}));

    p_valid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);
endmodule

// File: rtl/blit_scale_calc.sv
// Scaling factor calculator: computes mode and 16-bit factor for both axes
// of one copy job with a shared serial divider (horizontal, then vertical).
// Assumes: start is a level sampled on rising edges and only honoured idle;
// results and done change on the same edge, 2*(NUM_W+2) edges after accept.
module blit_scale_calc
    import scl_pkg::*;
#(
    parameter int EXT_W  = 16,
    parameter int FRAC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [EXT_W-1:0]  src_w,
    input  logic [EXT_W-1:0]  src_h,
    input  logic [EXT_W-1:0]  dst_w,
    input  logic [EXT_W-1:0]  dst_h,
    input  logic [1:0]        rot,
    input  logic              legacy,
    output logic              done,
    output logic [1:0]        mode_x,
    output logic [1:0]        mode_y,
    output logic [FRAC_W-1:0] factor_x,
    output logic [FRAC_W-1:0] factor_y,
    output logic              div_err
);
    localparam int NUM_W  = EXT_W + FRAC_W;
    localparam int N_AXIS = 2;
    localparam logic [NUM_W:0] FMAX = {{(NUM_W+1-FRAC_W){1'b0}}, {FRAC_W{1'b1}}};

    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN} st_e;

    st_e              state;
    logic             axis_sel;
    logic [EXT_W-1:0] p_src_w, p_src_h, p_tgt_w, p_tgt_h;
    logic [EXT_W-1:0] lat_src [N_AXIS];
    logic [EXT_W-1:0] lat_tgt [N_AXIS];
    logic [1:0]       pl_mode [N_AXIS];
    logic [NUM_W-1:0] pl_num  [N_AXIS];
    logic [EXT_W-1:0] pl_den  [N_AXIS];
    logic             pl_zero [N_AXIS];
    logic             div_load;
    logic [NUM_W-1:0] div_quo;
    logic             div_valid;
    logic [1:0]       hold_mode;
    logic [FRAC_W-1:0] hold_fac;
    logic             hold_err;
    logic [FRAC_W-1:0] cur_fac;
    logic [1:0]       cur_mode;
    logic             cur_zero;

    // Turns the raw quotient into the published factor with saturation.
    function automatic logic [FRAC_W-1:0] fin_factor(input logic [1:0] m,
                                                     input logic z,
                                                     input logic [NUM_W-1:0] q);
        logic [NUM_W:0] qq;
        qq = {1'b0, q} + {{NUM_W{1'b0}}, (m == SCL_DOWN)};
        if (m == SCL_NONE || z)
            return '0;
        else if (qq > FMAX)
            return {FRAC_W{1'b1}};
        else
            return qq[FRAC_W-1:0];
    endfunction

    scl_axis_prep #(.EXT_W(EXT_W)) u_prep (
        .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
        .rot(rot), .legacy(legacy),
        .eff_src_w(p_src_w), .eff_src_h(p_src_h),
        .tgt_w(p_tgt_w), .tgt_h(p_tgt_h)
    );

    for (genvar g = 0; g < N_AXIS; g++) begin : g_axis
        scl_axis_plan #(.EXT_W(EXT_W), .FRAC_W(FRAC_W)) u_plan (
            .src(lat_src[g]), .tgt(lat_tgt[g]),
            .mode(pl_mode[g]), .dividend(pl_num[g]),
            .divisor(pl_den[g]), .zero_div(pl_zero[g])
        );
    end

    // Purpose: feed the divider with the operands of the active axis.
    always_comb begin
        div_load = (state == ST_SETUP);
        cur_mode = pl_mode[axis_sel];
        cur_zero = pl_zero[axis_sel];
        cur_fac  = fin_factor(cur_mode, cur_zero, div_quo);
    end

    scl_restoring_div #(.NUM_W(NUM_W), .DEN_W(EXT_W)) u_div (
        .clk(clk), .rst_n(rst_n), .load(div_load),
        .num(pl_num[axis_sel]), .den(pl_den[axis_sel]),
        .quo(div_quo), .valid(div_valid)
    );

    // Purpose: sequence accept, two divider slots and publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            axis_sel  <= 1'b0;
            lat_src   <= '{default: '0};
            lat_tgt   <= '{default: '0};
            hold_mode <= '0;
            hold_fac  <= '0;
            hold_err  <= 1'b0;
            done      <= 1'b0;
            mode_x    <= '0;
            mode_y    <= '0;
            factor_x  <= '0;
            factor_y  <= '0;
            div_err   <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        lat_src[0] <= p_src_w;
                        lat_tgt[0] <= p_tgt_w;
                        lat_src[1] <= p_src_h;
                        lat_tgt[1] <= p_tgt_h;
                        axis_sel   <= 1'b0;
                        state      <= ST_SETUP;
                    end
                end
                ST_SETUP: state <= ST_RUN;
                ST_RUN: begin
                    if (div_valid) begin
                        if (!axis_sel) begin
                            hold_mode <= cur_mode;
                            hold_fac  <= cur_fac;
                            hold_err  <= cur_zero;
                            axis_sel  <= 1'b1;
                            state     <= ST_SETUP;
                        end else begin
                            mode_x   <= hold_mode;
                            factor_x <= hold_fac;
                            mode_y   <= cur_mode;
                            factor_y <= cur_fac;
                            div_err  <= hold_err | cur_zero;
                            done     <= 1'b1;
                            state    <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_extents_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |=> ($stable(lat_src[0]) && $stable(lat_src[1]) &&
                                $stable(lat_tgt[0]) && $stable(lat_tgt[1])));

    p_mode_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (mode_x != 2'd3 && mode_y != 2'd3));

    p_none_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((mode_x != SCL_NONE || factor_x == '0) &&
                  (mode_y != SCL_NONE || factor_y == '0)));

    p_down_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((mode_x != SCL_DOWN || factor_x != '0) &&
                  (mode_y != SCL_DOWN || factor_y != '0)));

    p_err_on_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && div_err) |-> ((mode_x == SCL_UP && factor_x == '0) ||
                               (mode_y == SCL_UP && factor_y == '0)));

    p_hold_results_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(mode_x) && $stable(mode_y) && $stable(factor_x) &&
                   $stable(factor_y) && $stable(div_err)));
endmodule

// File: tb/blit_scale_calc_test.sv
module blit_scale_calc_test;
    localparam int LAT = 68;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
    logic [1:0]  rot = '0;
    logic        legacy = 1'b0;
    logic        done;
    logic [1:0]  mode_x, mode_y;
    logic [15:0] factor_x, factor_y;
    logic        div_err;

    int    n_run = 0;
    int    n_fail = 0;
    string cur_tag = "R1";

    // reference model state
    bit m_busy = 0;
    int m_cnt = 0;
    int e_done = 0, e_mx = 0, e_my = 0, e_fx = 0, e_fy = 0, e_er = 0;
    int p_mx = 0, p_my = 0, p_fx = 0, p_fy = 0, p_er = 0;

    blit_scale_calc uut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
        .rot(rot), .legacy(legacy), .done(done),
        .mode_x(mode_x), .mode_y(mode_y),
        .factor_x(factor_x), .factor_y(factor_y), .div_err(div_err)
    );

    always #10 clk = ~clk;

    task automatic axis_ref(input int s, input int d, output int m, output int f, output int e);
        longint q;
        m = 0; f = 0; e = 0;
        if (s > d) begin
            m = 1;
            q = (longint'(d) << 16) / s + 1;
            f = (q > 65535) ? 65535 : int'(q);
        end else if (s < d) begin
            m = 2;
            if (d - 1 == 0) begin
                e = 1;
            end else begin
                q = (longint'((s - 1) & 16'hFFFF) << 16) / (d - 1);
                f = (q > 65535) ? 65535 : int'(q);
            end
        end
    endtask

    task automatic job_ref(input int sw, input int sh, input int dw, input int dh,
                           input int r, input int lg);
        int tw, th, ew, eh, ex, ey, ad;
        tw = (r % 2 == 1) ? dh : dw;
        th = (r % 2 == 1) ? dw : dh;
        ew = sw; eh = sh;
        ad = (sw > dh) ? sw - dh : dh - sw;
        if (lg != 0 && r % 2 == 1) begin
            if (dw == sh) eh = (sh - 8) & 16'hFFFF;
            if (ad < 16)  ew = (sw - 16) & 16'hFFFF;
        end
        axis_ref(ew, tw, p_mx, p_fx, ex);
        axis_ref(eh, th, p_my, p_fy, ey);
        p_er = ex | ey;
    endtask

    // Behavioural model advanced on every rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; e_done = 0;
            e_mx = 0; e_my = 0; e_fx = 0; e_fy = 0; e_er = 0;
        end else begin
            e_done = 0;
            if (m_busy) begin
                m_cnt++;
                if (m_cnt == LAT) begin
                    m_busy = 0; e_done = 1;
                    e_mx = p_mx; e_my = p_my; e_fx = p_fx; e_fy = p_fy; e_er = p_er;
                end
            end else if (start) begin
                job_ref(src_w, src_h, dst_w, dst_h, rot, legacy);
                m_busy = 1; m_cnt = 0;
            end
        end
    end

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_run++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            string t;
            t = (e_done != 0) ? cur_tag : "R12";
            chk("R2", "done", int'(done), e_done);
            chk(t, "mode_x", int'(mode_x), e_mx);
            chk(t, "mode_y", int'(mode_y), e_my);
            chk(t, "factor_x", int'(factor_x), e_fx);
            chk(t, "factor_y", int'(factor_y), e_fy);
            chk((e_done != 0) ? "R11" : "R12", "div_err", int'(div_err), e_er);
        end
    end

    task automatic run_job(input int sw, input int sh, input int dw, input int dh,
                           input int r, input int lg, input string tag);
        @(negedge clk);
        cur_tag = tag;
        src_w = 16'(sw); src_h = 16'(sh); dst_w = 16'(dw); dst_h = 16'(dh);
        rot = 2'(r); legacy = lg[0];
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset values
        chk("R1", "done", int'(done), 0);
        chk("R1", "factor_x", int'(factor_x), 0);
        chk("R1", "mode_y", int'(mode_y), 0);
        chk("R1", "div_err", int'(div_err), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        run_job(100, 50, 100, 50, 0, 0, "R5");      // equal extents
        run_job(200, 100, 100, 50, 0, 0, "R6");     // shrink both
        run_job(65535, 65535, 1, 2, 0, 0, "R6");    // extreme shrink
        run_job(100, 50, 200, 100, 0, 0, "R7");     // enlarge both
        run_job(0, 40, 2, 40, 0, 0, "R7");          // wrapped source, saturates
        run_job(100, 200, 200, 100, 1, 0, "R8");    // swap -> keep
        run_job(100, 200, 200, 100, 3, 0, "R8");
        run_job(100, 200, 200, 100, 2, 0, "R4");    // no swap: enlarge/shrink
        run_job(100, 64, 64, 90, 3, 1, "R9");       // both trims
        run_job(100, 64, 64, 90, 1, 1, "R9");
        run_job(300, 64, 50, 90, 1, 1, "R9");       // no trim condition
        run_job(100, 64, 64, 90, 0, 1, "R10");      // legacy ignored
        run_job(100, 64, 64, 90, 2, 1, "R10");
        run_job(0, 10, 1, 10, 0, 0, "R11");         // zero divisor on x
        run_job(10, 0, 10, 1, 0, 0, "R11");         // zero divisor on y

        // R3: extra start pulses and input changes while busy are ignored
        @(negedge clk);
        cur_tag = "R3";
        src_w = 16'd640; src_h = 16'd480; dst_w = 16'd320; dst_h = 16'd960;
        rot = 2'd0; legacy = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (10) @(negedge clk);
        src_w = 16'd7; dst_h = 16'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0; src_h = 16'd9;
        while (m_busy) @(negedge clk);
        @(negedge clk);

        // R3: start held high, new job taken right after done
        cur_tag = "R3";
        src_w = 16'd50; src_h = 16'd1000; dst_w = 16'd75; dst_h = 16'd999;
        start = 1'b1;
        repeat (150) @(negedge clk);
        start = 1'b0;
        while (m_busy) @(negedge clk);
        repeat (3) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule